// File: doc/BRIEF.md
# Banked NIC Register Interface

This block is the host-facing register front end of a network controller. A host reaches sixteen register offsets, and a bank field held in the block decides what each offset means. Offset 0 is always the command register. A write to it loads the bank number from its top two bits and passes the remaining six bits to a separate command decoder through a one-cycle strobe.

Bank 0 holds the control and status registers:
- an identification byte whose top two bits count the reads made of it, so probe software can confirm that a live device answers;
- an event status register, cleared by writing ones;
- an interrupt mask;
- two 16-bit receive ring registers;
- a host address pointer and a 16-bit data window into an internal packet RAM. Each access through the window moves the pointer on by one word.

Bank 1 holds four byte-wide page limits for the receive and transmit areas. Bank 2 has nothing in this block except the command register.

Host accesses are single-cycle. Read data is valid during the cycle in which the read is asserted. Register state changes on the rising edge that ends the access. If read and write are asserted together, the block treats the access as a write.

Top module: `nic_regbank_if`

## Requirements
- R1: A write to offset 0 in any bank loads the bank from data bits 7:6 (00 bank 0, 01 bank 1, 10 bank 2). The value 11 leaves the bank unchanged. Every such write raises `cmd_valid` in the same cycle, with `cmd_code` equal to data bits 5:0. Reading offset 0 returns the bank in bits 7:6 and zeros below. After reset the bank is 0.
- R2: In bank 0, a read of offset 2 returns a byte whose bits 5:0 are 0x24, so that byte ANDed with 0x2C equals 0x24.
- R3: Bits 7:6 of the identification byte are a counter that is 0 after reset. It advances by one (0x40 in byte terms, wrapping from 3 to 0) after each bank-0 read of offset 2, and it is left unchanged by every other access.
- R4: The bank-0 status register at offset 1 has four event bits: bit 0 receive-stop, bit 1 receive, bit 2 transmit, bit 3 execution. A high `evt_in` bit sets the matching status bit. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set and a clear of the same bit in one cycle leave it set. Bits 7:4 read 0.
- R5: The bank-0 interrupt mask at offset 3 holds bits 3:0 and resets to 0x0F. `irq` is high exactly when some status bit is 1 while its mask bit is 0.
- R6: Bank 0 has three 16-bit read/write registers, all reset to 0: receive base at offset 4, receive stop at offset 6 and host address pointer at offset 0x0C.
- R7: In bank 0, a write to offset 0x0E stores the 16-bit data at the RAM word the pointer addresses, and a read returns that word. After either access the pointer advances by 2, wrapping 0xFFFE to 0x0000.
- R8: The RAM word index is pointer bits [log2(RAM_WORDS):1]. Pointer bit 0 and the bits above the index are ignored, so with 128 words the pointer values 0x0000 and 0x0100 address the same word.
- R9: In bank 1, offsets 8, 9, 10 and 11 are byte-wide read/write limits (receive lower, receive upper, transmit lower, transmit upper), each reset to 0.
- R10: An offset with no register in the current bank reads 0 and ignores writes; writing it changes no register of any bank. A bank-1 read of offset 2 does not advance the counter of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 4 | Register offset |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wdata | input | 16 | Write data; byte registers use bits 7:0 |
| host_rdata | output | 16 | Read data, valid during the read cycle |
| evt_in | input | 4 | Event pulses that set status bits |
| irq | output | 1 | Unmasked event pending |
| cmd_valid | output | 1 | Command register written this cycle |
| cmd_code | output | 6 | Command code from data bits 5:0 |

## Verification
A wrong bank register shows up at once: the next access lands on the wrong register, and a read of offset 0 shows the bank itself. An identification counter that skips, or that counts reads it should not, appears on the very next identification read as a wrong value in bits 7:6. A status, mask or pointer fault appears at `irq` in the cycle after the event, or on the following readback. Faults in RAM indexing show up only when data is read back through an aliased or wrapped pointer, so the directed tests do exactly that.

// File: rtl/nic_rb_pkg.sv
package nic_rb_pkg;

  typedef enum logic [1:0] {
    BANK_CTRL = 2'd0,
    BANK_LIM  = 2'd1,
    BANK_AUX  = 2'd2,
    BANK_NONE = 2'd3
  } bank_e;

  // select vector positions
  localparam int S_CMD   = 0;
  localparam int S_STAT  = 1;
  localparam int S_ID    = 2;
  localparam int S_MASK  = 3;
  localparam int S_RBASE = 4;
  localparam int S_RSTOP = 5;
  localparam int S_HPTR  = 6;
  localparam int S_DPORT = 7;
  localparam int S_LIM0  = 8;
  localparam int NUM_LIM = 4;
  localparam int NSEL    = S_LIM0 + NUM_LIM;

  localparam logic [5:0] ID_FIXED = 6'h24;

endpackage

// File: rtl/nic_rb_decode.sv
module nic_rb_decode
  import nic_rb_pkg::*;
#(
  parameter int AW = 4
) (
  input  bank_e           bank,
  input  logic [AW-1:0]   addr,
  output logic [NSEL-1:0] sel
);

  always_comb begin
    sel = '0;
    if (addr == AW'(0)) begin
      sel[S_CMD] = 1'b1;
    end else begin
      case (bank)
        BANK_CTRL: begin
          case (addr)
            AW'(1):  sel[S_STAT]  = 1'b1;
            AW'(2):  sel[S_ID]    = 1'b1;
            AW'(3):  sel[S_MASK]  = 1'b1;
            AW'(4):  sel[S_RBASE] = 1'b1;
            AW'(6):  sel[S_RSTOP] = 1'b1;
            AW'(12): sel[S_HPTR]  = 1'b1;
            AW'(14): sel[S_DPORT] = 1'b1;
            default: sel = '0;
          endcase
        end
        BANK_LIM: begin
          for (int k = 0; k < NUM_LIM; k++) begin
            if (addr == AW'(8 + k)) sel[S_LIM0 + k] = 1'b1;
          end
        end
        default: sel = '0;
      endcase
    end
  end

endmodule

// File: rtl/nic_rb_idstat.sv
module nic_rb_idstat
  import nic_rb_pkg::*;
#(
  parameter int NEVT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_id,
  input  logic            wr_stat,
  input  logic            wr_mask,
  input  logic [NEVT-1:0] wbits,
  input  logic [NEVT-1:0] evt,
  output logic [7:0]      id_byte,
  output logic [7:0]      stat_byte,
  output logic [7:0]      mask_byte,
  output logic [1:0]      rot,
  output logic [NEVT-1:0] status,
  output logic            irq
);

  logic [1:0]      rot_q, rot_d;
  logic [NEVT-1:0] stat_q, stat_d;
  logic [NEVT-1:0] mask_q, mask_d;
  logic [NEVT-1:0] clr;

  always_comb begin
    rot_d = rot_q;
    if (rd_id) rot_d = rot_q + 2'd1;
  end

  always_comb begin
    clr    = wr_stat ? wbits : '0;
    stat_d = (stat_q & ~clr) | evt;
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q  <= '0;
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      rot_q  <= rot_d;
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign id_byte   = {rot_q, ID_FIXED};
  assign stat_byte = 8'(stat_q);
  assign mask_byte = 8'(mask_q);
  assign rot       = rot_q;
  assign status    = stat_q;
  assign irq       = |(stat_q & ~mask_q);

endmodule

// File: rtl/nic_rb_pram.sv
module nic_rb_pram #(
  parameter int RAM_WORDS = 128,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_load,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ptr,
  output logic [DW-1:0] rdata
);

  localparam int RAM_AW = $clog2(RAM_WORDS);

  logic [DW-1:0]     ptr_q, ptr_d;
  logic [RAM_AW-1:0] idx;
  logic [DW-1:0]     mem [RAM_WORDS];

  assign idx = ptr_q[RAM_AW:1];

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_load) begin
      ptr_d = wdata;
    end else if (acc_wr || acc_rd) begin
      ptr_d = ptr_q + DW'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wr) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
  assign ptr   = ptr_q;

endmodule

// File: rtl/nic_regbank_if.sv
module nic_regbank_if
  import nic_rb_pkg::*;
#(
  parameter int RAM_WORDS = 128,
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int NEVT      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  input  logic [NEVT-1:0] evt_in,
  output logic          irq,
  output logic          cmd_valid,
  output logic [5:0]    cmd_code
);

  localparam int BW = 8;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  logic            do_wr, do_rd;
  logic [NSEL-1:0] sel;
  bank_e           bank_q, bank_d;

  assign do_wr = host_wr;
  assign do_rd = host_rd & ~host_wr;

  nic_rb_decode #(.AW(AW)) u_dec (
    .bank (bank_q),
    .addr (host_addr),
    .sel  (sel)
  );

  // bank register
  always_comb begin
    bank_d = bank_q;
    if (do_wr && sel[S_CMD] && (host_wdata[7:6] != 2'b11)) begin
      bank_d = bank_e'(host_wdata[7:6]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_q <= BANK_CTRL;
    end else begin
      bank_q <= bank_d;
    end
  end

  assign cmd_valid = do_wr & sel[S_CMD];
  assign cmd_code  = host_wdata[5:0];

  // identification, status and mask
  logic [BW-1:0]   id_byte, stat_byte, mask_byte;
  logic [1:0]      id_rot;
  logic [NEVT-1:0] stat_bits;

  nic_rb_idstat #(.NEVT(NEVT)) u_idstat (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_id     (do_rd & sel[S_ID]),
    .wr_stat   (do_wr & sel[S_STAT]),
    .wr_mask   (do_wr & sel[S_MASK]),
    .wbits     (host_wdata[NEVT-1:0]),
    .evt       (evt_in),
    .id_byte   (id_byte),
    .stat_byte (stat_byte),
    .mask_byte (mask_byte),
    .rot       (id_rot),
    .status    (stat_bits),
    .irq       (irq)
  );

  // receive ring word registers
  logic [DW-1:0] rbase_q, rbase_d, rstop_q, rstop_d;

  always_comb begin
    rbase_d = rbase_q;
    rstop_d = rstop_q;
    if (do_wr && sel[S_RBASE]) rbase_d = host_wdata;
    if (do_wr && sel[S_RSTOP]) rstop_d = host_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rbase_q <= '0;
      rstop_q <= '0;
    end else begin
      rbase_q <= rbase_d;
      rstop_q <= rstop_d;
    end
  end

  // pointer and packet RAM window
  logic [DW-1:0] hptr, dport_rdata;

  nic_rb_pram #(.RAM_WORDS(RAM_WORDS), .DW(DW)) u_pram (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ptr_load (do_wr & sel[S_HPTR]),
    .acc_wr   (do_wr & sel[S_DPORT]),
    .acc_rd   (do_rd & sel[S_DPORT]),
    .wdata    (host_wdata),
    .ptr      (hptr),
    .rdata    (dport_rdata)
  );

  // bank 1 page limits
  logic [BW-1:0] lim_q [NUM_LIM];
  logic [BW-1:0] lim_d [NUM_LIM];

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
    always_comb begin
      lim_d[g] = lim_q[g];
      if (do_wr && sel[S_LIM0 + g]) lim_d[g] = host_wdata[BW-1:0];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        lim_q[g] <= '0;
      end else begin
        lim_q[g] <= lim_d[g];
      end
    end
  end

  // read data: select lines are one-hot, so an OR of gated sources
  always_comb begin
    host_rdata = '0;
    if (sel[S_CMD])   host_rdata = host_rdata | DW'({bank_q, 6'b0});
    if (sel[S_STAT])  host_rdata = host_rdata | DW'(stat_byte);
    if (sel[S_ID])    host_rdata = host_rdata | DW'(id_byte);
    if (sel[S_MASK])  host_rdata = host_rdata | DW'(mask_byte);
    if (sel[S_RBASE]) host_rdata = host_rdata | rbase_q;
    if (sel[S_RSTOP]) host_rdata = host_rdata | rstop_q;
    if (sel[S_HPTR])  host_rdata = host_rdata | hptr;
    if (sel[S_DPORT]) host_rdata = host_rdata | dport_rdata;
    for (int k = 0; k < NUM_LIM; k++) begin
      if (sel[S_LIM0 + k]) host_rdata = host_rdata | DW'(lim_q[k]);
    end
  end

endmodule

// File: rtl/nic_rb_checker.sv
module nic_rb_checker
  import nic_rb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSEL-1:0] sel,
  input logic            do_wr,
  input logic            do_rd,
  input logic [1:0]      wbank,
  input logic [3:0]      wclr,
  input logic [7:0]      rbyte,
  input logic [3:0]      evt,
  input logic [1:0]      bank,
  input logic [1:0]      rot,
  input logic [3:0]      status,
  input logic [15:0]     ptr
);

  logic wr_cmd, wr_stat, rd_id, dp_acc;
  assign wr_cmd  = do_wr & sel[S_CMD];
  assign wr_stat = do_wr & sel[S_STAT];
  assign rd_id   = do_rd & sel[S_ID];
  assign dp_acc  = (do_wr | do_rd) & sel[S_DPORT];

  a_r1_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wbank != 2'b11) |=> (bank == $past(wbank)));

  a_r1_bank_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wbank == 2'b11) |=> $stable(bank));

  a_r2_id_sig: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |-> ((rbyte & 8'h2C) == 8'h24));

  a_r3_rot_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |=> (rot == $past(rot) + 2'd1));

  a_r3_rot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_id |=> $stable(rot));

  a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != 4'h0) |=> ((status & $past(evt)) == $past(evt)));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((status & $past(wclr) & ~$past(evt)) == 4'h0));

  a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    dp_acc |=> (ptr == $past(ptr) + 16'd2));

  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

bind nic_regbank_if nic_rb_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .sel    (sel),
  .do_wr  (do_wr),
  .do_rd  (do_rd),
  .wbank  (host_wdata[7:6]),
  .wclr   (host_wdata[3:0]),
  .rbyte  (host_rdata[7:0]),
  .evt    (evt_in),
  .bank   (bank_q),
  .rot    (id_rot),
  .status (stat_bits),
  .ptr    (hptr)
);

// File: tb/sim_nic_regbank_if.sv
module sim_nic_regbank_if;

  logic        clk;
  logic        rst_n;
  logic [3:0]  host_addr;
  logic        host_wr;
  logic        host_rd;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [3:0]  evt_in;
  logic        irq;
  logic        cmd_valid;
  logic [5:0]  cmd_code;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  nic_regbank_if u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .evt_in     (evt_in),
    .irq        (irq),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [3:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = 4'h0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(4'h0, d);  chk("R1 reset bank", d, 16'h0000);
    rd(4'h3, d);  chk("R5 reset mask", d, 16'h000F);
    rd(4'h1, d);  chk("R4 reset status", d, 16'h0000);
    chk("R5 reset irq", {15'b0, irq}, 16'h0000);
    rd(4'hC, d);  chk("R6 reset pointer", d, 16'h0000);
  endtask

  task automatic t_id;
    logic [15:0] d;
    rd(4'h2, d);  chk("R2 id masked", d & 16'h002C, 16'h0024);
    chk("R3 first id", d, 16'h0024);
    rd(4'h2, d);  chk("R3 second id", d, 16'h0064);
    rd(4'h2, d);  chk("R3 third id", d, 16'h00A4);
    rd(4'h2, d);  chk("R3 fourth id", d, 16'h00E4);
    rd(4'h2, d);  chk("R3 id wrap", d, 16'h0024);
    rd(4'h1, d);
    rd(4'h2, d);  chk("R3 other read no advance", d, 16'h0064);
  endtask

  task automatic t_cmd;
    logic [15:0] d;
    @(negedge clk);
    host_addr = 4'h0; host_wdata = 16'h004B; host_wr = 1'b1;
    #1 chk("R1 cmd_valid high", {15'b0, cmd_valid}, 16'h0001);
    chk("R1 cmd_code", {10'b0, cmd_code}, 16'h000B);
    @(negedge clk);
    host_wr = 1'b0;
    #1 chk("R1 cmd_valid low", {15'b0, cmd_valid}, 16'h0000);
    rd(4'h0, d);  chk("R1 bank1 selected", d, 16'h0040);
    wr(4'h0, 16'h00C5);
    rd(4'h0, d);  chk("R1 code 11 keeps bank", d, 16'h0040);
    wr(4'h0, 16'h0080);
    rd(4'h0, d);  chk("R1 bank2 selected", d, 16'h0080);
    wr(4'h0, 16'h0000);
    rd(4'h0, d);  chk("R1 bank0 selected", d, 16'h0000);
  endtask

  task automatic t_status;
    logic [15:0] d;
    pulse_evt(4'b0110);
    rd(4'h1, d);  chk("R4 events set", d, 16'h0006);
    chk("R5 all masked", {15'b0, irq}, 16'h0000);
    wr(4'h3, 16'h000B);
    chk("R5 tx unmasked irq", {15'b0, irq}, 16'h0001);
    wr(4'h1, 16'h0004);
    rd(4'h1, d);  chk("R4 w1c tx", d, 16'h0002);
    chk("R5 irq drops", {15'b0, irq}, 16'h0000);
    wr(4'h1, 16'h0000);
    rd(4'h1, d);  chk("R4 write zero no effect", d, 16'h0002);
    @(negedge clk);
    host_addr = 4'h1; host_wdata = 16'h0008; host_wr = 1'b1; evt_in = 4'h8;
    @(negedge clk);
    host_wr = 1'b0; evt_in = 4'h0;
    rd(4'h1, d);  chk("R4 set wins over clear", d, 16'h000A);
    wr(4'h1, 16'h00FF);
    rd(4'h1, d);  chk("R4 clear all", d, 16'h0000);
    wr(4'h3, 16'h000F);
  endtask

  task automatic t_words;
    logic [15:0] d;
    wr(4'h4, 16'hA55A);
    wr(4'h6, 16'h3C7E);
    rd(4'h4, d);  chk("R6 receive base", d, 16'hA55A);
    rd(4'h6, d);  chk("R6 receive stop", d, 16'h3C7E);
  endtask

  task automatic t_dport;
    logic [15:0] d;
    wr(4'hC, 16'h0010);
    wr(4'hE, 16'hAAAA);
    wr(4'hE, 16'hBBBB);
    rd(4'hC, d);  chk("R7 pointer after writes", d, 16'h0014);
    wr(4'hC, 16'h0010);
    rd(4'hE, d);  chk("R7 first word", d, 16'hAAAA);
    rd(4'hE, d);  chk("R7 second word", d, 16'hBBBB);
    rd(4'hC, d);  chk("R7 pointer after reads", d, 16'h0014);
    wr(4'hC, 16'hFFFE);
    wr(4'hE, 16'hCCCC);
    rd(4'hC, d);  chk("R7 pointer wrap", d, 16'h0000);
  endtask

  task automatic t_alias;
    logic [15:0] d;
    wr(4'hC, 16'h0000);
    wr(4'hE, 16'h1234);
    wr(4'hC, 16'h0100);
    rd(4'hE, d);  chk("R8 aliased word", d, 16'h1234);
    wr(4'hC, 16'h00FF);
    rd(4'hE, d);  chk("R8 bit0 ignored", d, 16'hCCCC);
  endtask

  task automatic t_limits;
    logic [15:0] d;
    wr(4'h0, 16'h0040);
    wr(4'h8, 16'h0011);
    wr(4'h9, 16'h0022);
    wr(4'hA, 16'h0033);
    wr(4'hB, 16'hFF44);
    rd(4'h8, d);  chk("R9 rx lower", d, 16'h0011);
    rd(4'h9, d);  chk("R9 rx upper", d, 16'h0022);
    rd(4'hA, d);  chk("R9 tx lower", d, 16'h0033);
    rd(4'hB, d);  chk("R9 tx upper", d, 16'h0044);
  endtask

  task automatic t_isolation;
    logic [15:0] d;
    wr(4'h3, 16'h0000);
    rd(4'h2, d);  chk("R10 bank1 offset2 reads 0", d, 16'h0000);
    rd(4'hC, d);  chk("R10 bank1 offset C reads 0", d, 16'h0000);
    wr(4'h0, 16'h0080);
    wr(4'h8, 16'h0055);
    rd(4'h8, d);  chk("R10 bank2 offset8 reads 0", d, 16'h0000);
    wr(4'h0, 16'h0040);
    rd(4'h8, d);  chk("R10 limit untouched by bank2", d, 16'h0011);
    wr(4'h0, 16'h0000);
    rd(4'h3, d);  chk("R10 mask untouched by bank1", d, 16'h000F);
    rd(4'h2, d);  chk("R10 bank1 id read not counted", d, 16'h00A4);
    rd(4'h5, d);  chk("R10 unused offset reads 0", d, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; evt_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset;
    t_id;
    t_cmd;
    t_status;
    t_words;
    t_dport;
    t_alias;
    t_limits;
    t_isolation;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule